// File: doc/BRIEF.md
# Vectored Event Interrupt Controller

This block sits beside a processor core and turns sixteen event request lines into program-counter redirections. Software programs one 32-bit target address per line and an enable mask over a small memory-mapped register window. When the core reaches an instruction boundary and is ready to take a new program counter, the controller hands over the target of the lowest-numbered enabled line that is requesting. In the same cycle it completes that line's valid/ready handshake.

A line whose enable bit is clear never sees its ready go high. Its source simply waits in the handshake until software enables it, so it is never serviced through a target that has not been programmed. A separate restart request takes precedence over every event. It delivers a fixed restart address, and in the cycle after acceptance it wipes the whole target table and the enable mask. This lets software re-arm everything from scratch after a restart.

Top module: `evt_vector_ctrl`

## Requirements
- R1: After `rst_n` is held low for a clock edge, every target register and the enable mask read as zero, and no `evt_ready` bit is high.
- R2: The target register of line N sits at byte offset 4*N (N = 0..15). It holds a full 32-bit value that a write stores and a later read returns unchanged.
- R3: The enable mask sits at byte offset 64 and reads back all 32 written bits. Bit N (N = 0..15) enables line N, and bits 31:16 gate nothing.
- R4: While bit N of the enable mask is clear, `evt_ready[N]` stays low whatever the other inputs are.
- R5: When line N is accepted (`evt_valid[N]` and `evt_ready[N]` both high), `pc_valid` is high in that cycle and `pc_value` equals the value most recently written to target N.
- R6: If several enabled lines request together, only the lowest-numbered one has its ready raised. At most one `evt_ready` bit is ever high.
- R7: While `at_boundary` is low, `pc_valid`, `rst_req_ready` and every `evt_ready` bit stay low.
- R8: While `at_boundary` and `rst_req_valid` are both high, `pc_value` equals the `RESET_VEC` parameter (default 0x0000_0100) and no `evt_ready` bit is high, even when enabled lines are requesting.
- R9: An accepted restart request (`rst_req_valid`, `at_boundary` and `pc_ready` high) clears every target register and the enable mask at that clock edge. A bus write in the same cycle is discarded.
- R10: A bus access to an offset that is not a multiple of 4, or above 64, reads as zero and leaves every register unchanged. `bus_rdata` is zero whenever `bus_rd_en` is low.
- R11: While `pc_ready` is low, no `evt_ready` bit and not `rst_req_ready` is high, so nothing is accepted without being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_valid | input | 16 | Per-line event request |
| evt_ready | output | 16 | Per-line acceptance, at most one bit high |
| rst_req_valid | input | 1 | Restart request |
| rst_req_ready | output | 1 | Restart acceptance |
| at_boundary | input | 1 | Core is between instructions |
| pc_valid | output | 1 | A new program counter is offered |
| pc_ready | input | 1 | Core takes the offered program counter |
| pc_value | output | 32 | Offered program counter, zero when not valid |

## Verification
On every cycle the assertions check the following:
- At most one line is granted, and that line is enabled and the lowest requesting one.
- Nothing is offered away from a boundary, and nothing is accepted while the core holds off.
- The restart address wins over pending events.
- The mask is zero after an accepted restart.

Only the bench's scenarios can show the storage side: targets written at given offsets come back on delivery, misaligned and out-of-window writes leave the table untouched, and a write racing an accepted restart is lost. These scenarios compare against a behavioural model on every clock.

// File: rtl/evc_pkg.sv
// Shared types for the vectored event interrupt controller.
package evc_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/evc_regfile.sv
// Target table and enable mask behind a simple read/write strobe bus.
// Assumes N_EVT <= 32 and ADDR_W wide enough to reach offset 4*N_EVT.
// Offsets below 4*N_EVT that are multiples of 4 select a target register,
// offset 4*N_EVT selects the mask, and every other offset reads zero.
module evc_regfile
    import evc_pkg::*;
#(
    parameter int N_EVT  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             rdata_o,
    output logic [N_EVT-1:0]  mask_o,
    output word_t             vec_o [N_EVT]
);
    localparam int IDX_W    = $clog2(N_EVT);
    localparam int MASK_OFS = 4 * N_EVT;

    word_t            vec_q [N_EVT];
    word_t            mask_q;
    logic             aligned;
    logic             in_vec;
    logic             at_mask;
    logic [IDX_W-1:0] idx;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign in_vec  = aligned && (int'(addr_i) < MASK_OFS);
    assign at_mask = (int'(addr_i) == MASK_OFS);
    assign idx     = addr_i[IDX_W+1:2];

    // One storage register per line; restart or reset wipes it.
    for (genvar k = 0; k < N_EVT; k++) begin : g_vec
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                vec_q[k] <= '0;
            end else if (wr_en_i && in_vec && idx == IDX_W'(k)) begin
                vec_q[k] <= wdata_i;
            end
        end
        assign vec_o[k] = vec_q[k];
    end

    // Enable mask register, cleared alongside the table.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            mask_q <= '0;
        end else if (wr_en_i && at_mask) begin
            mask_q <= wdata_i;
        end
    end

    assign mask_o = mask_q[N_EVT-1:0];

    // Read mux: zero for idle strobe and for unmapped offsets.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if (in_vec) begin
                rdata_o = vec_q[idx];
            end else if (at_mask) begin
                rdata_o = mask_q;
            end
        end
    end

    // R9: a restart taken at this edge leaves the mask empty afterwards
    p_mask_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_q == '0));

endmodule

// File: rtl/evc_arbiter.sv
// Fixed-order selector: among requesting lines whose enable bit is set,
// the lowest index wins. Purely combinational; the clock and reset are
// used only by the assertions beside the logic.
module evc_arbiter #(
    parameter int N_EVT = 16,
    localparam int IDX_W = $clog2(N_EVT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] req_i,
    input  logic [N_EVT-1:0] en_i,
    output logic [N_EVT-1:0] grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] sel_o
);
    logic [N_EVT-1:0] live;

    assign live  = req_i & en_i;
    assign any_o = |live;

    // Scan from the top so the lowest live line is the last one kept.
    always_comb begin
        grant_o = '0;
        sel_o   = '0;
        for (int k = N_EVT - 1; k >= 0; k--) begin
            if (live[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                sel_o      = IDX_W'(k);
            end
        end
    end

    // R6: never more than one line selected
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R4: a selected line always has its enable bit set
    p_grant_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~en_i) == '0);

    // R6: no live line below the selected one
    p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (((grant_o - N_EVT'(1)) & req_i & en_i) == '0));

endmodule

// File: rtl/evt_vector_ctrl.sv
// Vectored event interrupt controller, top level.
// Offers a new program counter only while the core sits at an instruction
// boundary. A restart request outranks events and delivers RESET_VEC; its
// acceptance wipes the target table and the enable mask. An event line is
// accepted only when enabled, selected, and the core takes the offer.
// Assumes the core holds at_boundary high for the whole delivery cycle.
module evt_vector_ctrl
    import evc_pkg::*;
#(
    parameter int    N_EVT     = 16,
    parameter int    ADDR_W    = 8,
    parameter word_t RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_EVT-1:0]  evt_valid,
    output logic [N_EVT-1:0]  evt_ready,
    input  logic              rst_req_valid,
    output logic              rst_req_ready,
    input  logic              at_boundary,
    output logic              pc_valid,
    input  logic              pc_ready,
    output logic [31:0]       pc_value
);
    localparam int IDX_W = $clog2(N_EVT);

    logic [N_EVT-1:0] mask;
    word_t            vec [N_EVT];
    logic [N_EVT-1:0] grant;
    logic             any_live;
    logic [IDX_W-1:0] sel;
    logic             slot;
    logic             take_rst;
    logic             take_evt;

    evc_regfile #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (take_rst),
        .wr_en_i (bus_wr_en),
        .rd_en_i (bus_rd_en),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .mask_o  (mask),
        .vec_o   (vec)
    );

    evc_arbiter #(.N_EVT(N_EVT)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (evt_valid),
        .en_i    (mask),
        .grant_o (grant),
        .any_o   (any_live),
        .sel_o   (sel)
    );

    // Acceptance window: boundary reached and core willing to redirect.
    assign slot     = at_boundary && pc_ready;
    assign take_rst = slot && rst_req_valid;
    assign take_evt = slot && !rst_req_valid;

    // Handshake outputs toward the requesters.
    assign rst_req_ready = slot;
    assign evt_ready     = take_evt ? grant : '0;

    // Program-counter offer toward the core; restart outranks events.
    always_comb begin
        pc_valid = at_boundary && (rst_req_valid || any_live);
        pc_value = '0;
        if (pc_valid) begin
            pc_value = rst_req_valid ? RESET_VEC : vec[sel];
        end
    end

    // R7: nothing offered or accepted mid-instruction
    p_boundary_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |-> (!pc_valid && !rst_req_ready && evt_ready == '0));

    // R8: restart address wins over pending events
    p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && rst_req_valid) |-> (pc_valid && pc_value == RESET_VEC && evt_ready == '0));

    // R11: no acceptance while the core holds off
    p_no_accept_on_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_ready |-> (!rst_req_ready && evt_ready == '0));

    // R5: a taken offer without restart retires exactly one line
    p_offer_retires_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && pc_ready && !rst_req_valid) |-> ($countones(evt_ready) == 1));

endmodule

// File: tb/evt_vector_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for evt_vector_ctrl: a behavioural model (arrays and integers) is
// updated at each rising edge and compared with the outputs at each falling
// edge. Directed scenarios walk through every requirement.
module evt_vector_ctrl_tb;
    localparam logic [31:0] RVEC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_valid = '0;
    logic [15:0] evt_ready;
    logic        rst_req_valid = 1'b0;
    logic        rst_req_ready;
    logic        at_boundary = 1'b0;
    logic        pc_valid;
    logic        pc_ready = 1'b0;
    logic [31:0] pc_value;

    int    checks = 0;
    int    failures = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [31:0] vec_m [16];
    logic [31:0] mask_m = '0;

    always #2.5 clk = ~clk;

    evt_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .rst_req_valid(rst_req_valid), .rst_req_ready(rst_req_ready),
        .at_boundary(at_boundary), .pc_valid(pc_valid),
        .pc_ready(pc_ready), .pc_value(pc_value)
    );

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Model state update at the edge, from the inputs held across it.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n || (at_boundary && pc_ready && rst_req_valid)) begin
            foreach (vec_m[k]) vec_m[k] = '0;
            mask_m = '0;
        end else if (bus_wr_en) begin
            if (bus_addr == 8'd64) mask_m = bus_wdata;
            else if (bus_addr < 8'd64 && bus_addr[1:0] == 2'b00) vec_m[bus_addr >> 2] = bus_wdata;
        end
    end

    // Compare outputs in the middle of the cycle.
    always @(negedge clk) begin
        if (started && rst_n) begin
            logic [15:0] live;
            int          selk;
            logic        e_pv;
            logic [31:0] e_val, e_rd;
            logic [15:0] e_er;
            live = evt_valid & mask_m[15:0];
            selk = -1;
            for (int k = 0; k < 16; k++) if (live[k] && selk < 0) selk = k;
            e_pv  = at_boundary && (rst_req_valid || live != 0);
            e_val = !e_pv ? 32'h0 : (rst_req_valid ? RVEC : vec_m[selk]);
            e_er  = (at_boundary && pc_ready && !rst_req_valid && selk >= 0) ? (16'h1 << selk) : 16'h0;
            e_rd  = 32'h0;
            if (bus_rd_en) begin
                if (bus_addr == 8'd64) e_rd = mask_m;
                else if (bus_addr < 8'd64 && bus_addr[1:0] == 2'b00) e_rd = vec_m[bus_addr >> 2];
            end
            chk("pc_valid", {31'b0, pc_valid}, {31'b0, e_pv});
            chk("pc_value", pc_value, e_val);
            chk("evt_ready", {16'b0, evt_ready}, {16'b0, e_er});
            chk("rst_req_ready", {31'b0, rst_req_ready}, {31'b0, at_boundary && pc_ready});
            chk("bus_rdata", bus_rdata, e_rd);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_w(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_r(input logic [7:0] a);
        bus_rd_en = 1'b1; bus_addr = a;
        cyc();
        bus_rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        for (int k = 0; k <= 64; k += 4) bus_r(8'(k));
        evt_valid = 16'hFFFF; at_boundary = 1'b1; pc_ready = 1'b1;
        cyc();
        evt_valid = '0;

        // R2: target registers round trip
        cur_req = "R2";
        for (int k = 0; k < 16; k++) bus_w(8'(4 * k), 32'hC0DE_0000 + 32'(k * 32'h111));
        for (int k = 15; k >= 0; k--) bus_r(8'(4 * k));

        // R3: mask holds all 32 bits
        cur_req = "R3";
        bus_w(8'd64, 32'hA5A5_0000);
        bus_r(8'd64);
        evt_valid = 16'hFFFF;
        cyc();
        evt_valid = '0;

        // R4: disabled lines never accepted
        cur_req = "R4";
        bus_w(8'd64, 32'h0000_0000);
        evt_valid = 16'hFFFF;
        repeat (3) cyc();
        evt_valid = '0;

        // R6 / R5: lowest enabled line first, delivered target
        cur_req = "R6";
        bus_w(8'd64, 32'h0000_8220);
        evt_valid = 16'h8228;
        cyc();
        cur_req = "R5";
        evt_valid = 16'h8208;
        cyc();
        evt_valid = 16'h8008;
        cyc();
        evt_valid = 16'h0008;
        cyc();
        evt_valid = '0;
        bus_w(8'd36, 32'hFEED_BEEF);
        cur_req = "R5";
        evt_valid = 16'h0200;
        cyc();
        evt_valid = '0;

        // R7: nothing between boundaries
        cur_req = "R7";
        at_boundary = 1'b0;
        evt_valid = 16'h0220;
        rst_req_valid = 1'b1;
        repeat (3) cyc();
        rst_req_valid = 1'b0;
        at_boundary = 1'b1;
        cyc();
        evt_valid = '0;

        // R11: core holding off accepts nothing
        cur_req = "R11";
        pc_ready = 1'b0;
        evt_valid = 16'h0020;
        repeat (2) cyc();
        rst_req_valid = 1'b1;
        cyc();
        rst_req_valid = 1'b0;
        bus_r(8'd64);
        pc_ready = 1'b1;
        cyc();
        evt_valid = '0;

        // R10: misaligned and out-of-window accesses
        cur_req = "R10";
        bus_w(8'd2, 32'h1111_1111);
        bus_w(8'd65, 32'hFFFF_FFFF);
        bus_w(8'd68, 32'h2222_2222);
        bus_w(8'd128, 32'h3333_3333);
        bus_w(8'd255, 32'h4444_4444);
        bus_r(8'd0);
        bus_r(8'd2);
        bus_r(8'd64);
        bus_r(8'd65);
        bus_r(8'd68);
        bus_r(8'd252);
        bus_rd_en = 1'b0; bus_addr = 8'd4;
        cyc();

        // R8: restart outranks pending enabled events
        cur_req = "R8";
        bus_w(8'd64, 32'h0000_FFFF);
        evt_valid = 16'h0008;
        rst_req_valid = 1'b1; pc_ready = 1'b0;
        cyc();
        pc_ready = 1'b1;
        cyc();
        rst_req_valid = 1'b0;
        cyc();
        evt_valid = '0;

        // R9: restart clears table and mask; racing write lost
        cur_req = "R9";
        bus_w(8'd64, 32'h0000_00FF);
        bus_w(8'd12, 32'h0BAD_F00D);
        rst_req_valid = 1'b1;
        bus_w(8'd4, 32'h1234_5678);
        rst_req_valid = 1'b0;
        for (int k = 0; k <= 64; k += 4) bus_r(8'(k));
        evt_valid = 16'h0008;
        cyc();
        evt_valid = '0;

        // R1: reset pulse mid-run clears everything
        cur_req = "R1";
        bus_w(8'd64, 32'h0000_0001);
        bus_w(8'd0, 32'h5555_AAAA);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        bus_r(8'd0);
        bus_r(8'd64);
        evt_valid = 16'h0001;
        cyc();
        evt_valid = '0;
        cyc();

        finish_run();
    end
endmodule